// File: doc/BRIEF.md
# Sixty-Four-Source Interrupt Controller

This block gathers sixty-four active-low interrupt inputs and presents them to a processor through a small 32-bit register bus. The per-source state is exposed as two 32-bit words: a high word and a low word. Each word has an enable (mask) register and a pending register. The register bit that belongs to a given source comes from a fixed, irregular placement rule rather than from the source number, and several ranges run in reversed bit order.

Each source is sensed in one of three ways:
- Most internal sources are always active-low level.
- A group of seven external sources can be set to either level or falling edge.
- A group of sixteen port sources can be set to either falling edge only or both edges.

Software enables sources through the mask words and acknowledges edge events by writing ones to the pending words. It reads a vector register that names the lowest-numbered source that is both pending and enabled. A single request output is raised whenever such a source exists.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every readable register returns zero and `irq_o` is low.
- R2: Enable words sit at address 0 (high) and 1 (low) and read back as written. An enable bit of 1 lets its source through, and 0 keeps it from `irq_o` and the vector.
- R3: Sources whose number bit 4 is clear (0–15, 32–47) use the high word, and the rest use the low word. Bit positions are: source n in 1–15 at 16−n; 16–18 at 18−n; 19–30 at 33−n; 31 at 0; 32–47 at 63−n; 48–63 at n−32.
- R4: Pending words sit at address 2 (high) and 3 (low). Writing a 1 clears the edge-latched state of every source mapped to that bit, and writing 0 changes nothing. An edge event stays pending until cleared.
- R5: A level-sensed source reads pending one clock after its input goes low. It stays pending while the input is low, even across a clear write, and drops one clock after the input returns high.
- R6: The sense-select register at address 4 keeps only bits 8–14 and 16–31. All other bits read as zero.
- R7: External sources 19–25 use sense-select bit 33−n. With the bit at 1, a falling edge is latched. With the bit at 0, the source is active-low level.
- R8: Port sources 48–63 use sense-select bit n−32. With the bit at 1, only falling edges are latched. With the bit at 0, both falling and rising edges are latched.
- R9: The vector register at address 5 returns, in bits 31:26, the lowest-numbered source that is pending and enabled. All other bits are zero, and the value is 0 when no such source exists.
- R10: `irq_o` is high exactly when at least one enabled source is pending.
- R11: Source 0 never becomes pending. Source 31 shares low-word bit 0 with source 18: one enable bit gates both, and the pending bit shows either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_n | input | NSRC | Active-low interrupt inputs, bit index = source number |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe, committed on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational from register state |
| irq_o | output | 1 | Request to the processor |

## Verification
The bench builds the block with its defaults: 64 sources, 32-bit data and a 3-bit address. These are the only values the fixed placement rule admits, so every word, bit and sense group is reachable. A vector table sweeps each placement range and each end of it, including the reversed ranges, so a swapped or shifted bit shows up in the pending readback. Directed tests then cover the sense modes, the priority among several pending sources, the shared bit, and the dead source 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [1:0] {
      SENSE_NONE  = 2'd0,
      SENSE_LEVEL = 2'd1,
      SENSE_EXT   = 2'd2,
      SENSE_PORT  = 2'd3
   } sense_e;

   localparam int RA_MASK_HI = 0;
   localparam int RA_MASK_LO = 1;
   localparam int RA_PEND_HI = 2;
   localparam int RA_PEND_LO = 3;
   localparam int RA_SENSE   = 4;
   localparam int RA_VECTOR  = 5;

   // 0 = high word, 1 = low word
   function automatic int src_word(input int n);
      return ((n % 32) >= 16) ? 1 : 0;
   endfunction

   function automatic int src_bit(input int n);
      if (n == 0)       return 0;
      else if (n <= 15) return 16 - n;
      else if (n <= 18) return 18 - n;
      else if (n <= 30) return 33 - n;
      else if (n == 31) return 0;
      else if (n <= 47) return 63 - n;
      else              return n - 32;
   endfunction

   function automatic sense_e src_sense(input int n);
      if (n == 0)                 return SENSE_NONE;
      else if (n >= 19 && n <= 25) return SENSE_EXT;
      else if (n >= 48)            return SENSE_PORT;
      else                         return SENSE_LEVEL;
   endfunction

   // bit in the sense-select register, -1 when the source has none
   function automatic int sel_bit(input int n);
      if (n >= 19 && n <= 25) return 33 - n;
      else if (n >= 48)       return n - 32;
      else                    return -1;
   endfunction

   function automatic logic [31:0] sel_writable(input int nsrc);
      logic [31:0] m;
      m = '0;
      for (int n = 0; n < nsrc; n++)
         if (sel_bit(n) >= 0) m[sel_bit(n)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
   import irqc_pkg::*;
#(
   parameter sense_e SENSE = SENSE_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_n,
   input  logic sel,
   input  logic clr,
   output logic pend
);

   logic prev_q;
   logic pend_q;
   logic pend_d;
   logic fall, rise;
   logic level_mode, edge_mode, both_mode;

   assign fall = prev_q & ~src_n;
   assign rise = ~prev_q & src_n;

   always_comb begin
      level_mode = (SENSE == SENSE_LEVEL) || ((SENSE == SENSE_EXT) && !sel);
      edge_mode  = ((SENSE == SENSE_EXT) && sel) || (SENSE == SENSE_PORT);
      both_mode  = (SENSE == SENSE_PORT) && !sel;
      if (SENSE == SENSE_NONE)
         pend_d = 1'b0;
      else if (level_mode)
         pend_d = ~src_n;
      else
         pend_d = (pend_q & ~clr) | fall | (both_mode & rise);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         prev_q <= src_n;
         pend_q <= pend_d;
      end
   end

   assign pend = pend_q;

   // R4: a latched edge event survives until a clear write
   a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && pend_q && !clr) |=> (pend_q || !edge_mode));

   generate
      if (SENSE == SENSE_LEVEL) begin : g_lvl_chk
         // R5: level sources follow the input one clock later
         a_r5_level_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_n) |=> pend_q);
         a_r5_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
            src_n |=> !pend_q);
      end
      if (SENSE == SENSE_PORT) begin : g_port_chk
         // R8: falling-only mode never latches on a rising input
         a_r8_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && !pend_q && rise) |=> !pend_q);
      end
   endgenerate

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int NSRC  = 64,
   parameter int VEC_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  req,
   output logic [VEC_W-1:0] vec
);

   // lowest index wins; index 0 yields the "none" code
   always_comb begin
      vec = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (req[i]) vec = VEC_W'(i);
   end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int NSRC   = 64,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int VEC_W   = $clog2(NSRC);
   localparam int VEC_LSB = DATA_W - VEC_W;
   localparam logic [DATA_W-1:0] SEL_WMASK = sel_writable(NSRC);

   generate
      if (NSRC != 64) begin : g_bad_nsrc
         $error("irq_vector_ctrl: placement rule is defined for 64 sources only");
      end
      if (DATA_W != 32) begin : g_bad_width
         $error("irq_vector_ctrl: register words must be 32 bits");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("irq_vector_ctrl: address must reach six registers");
      end
   endgenerate

   logic [DATA_W-1:0] mask_hi, mask_lo, sel_q;
   logic [DATA_W-1:0] clr_hi, clr_lo;
   logic [DATA_W-1:0] view_hi, view_lo;
   logic [NSRC-1:0]   pend, en, clr, sel_src, active;
   logic [VEC_W-1:0]  win_vec;

   logic wr_mhi, wr_mlo, wr_phi, wr_plo, wr_sel;
   assign wr_mhi = bus_we && (bus_addr == ADDR_W'(RA_MASK_HI));
   assign wr_mlo = bus_we && (bus_addr == ADDR_W'(RA_MASK_LO));
   assign wr_phi = bus_we && (bus_addr == ADDR_W'(RA_PEND_HI));
   assign wr_plo = bus_we && (bus_addr == ADDR_W'(RA_PEND_LO));
   assign wr_sel = bus_we && (bus_addr == ADDR_W'(RA_SENSE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_hi <= '0;
         mask_lo <= '0;
         sel_q   <= '0;
      end else begin
         if (wr_mhi) mask_hi <= bus_wdata;
         if (wr_mlo) mask_lo <= bus_wdata;
         if (wr_sel) sel_q   <= bus_wdata & SEL_WMASK;
      end
   end

   assign clr_hi = wr_phi ? bus_wdata : '0;
   assign clr_lo = wr_plo ? bus_wdata : '0;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         localparam int W = src_word(s);
         localparam int B = src_bit(s);
         localparam int E = sel_bit(s);

         if (W == 1) begin : g_lo
            assign en[s]  = mask_lo[B];
            assign clr[s] = clr_lo[B];
         end else begin : g_hi
            assign en[s]  = mask_hi[B];
            assign clr[s] = clr_hi[B];
         end

         if (E >= 0) begin : g_sel
            assign sel_src[s] = sel_q[E];
         end else begin : g_nosel
            assign sel_src[s] = 1'b0;
         end

         irqc_src_cell #(.SENSE(src_sense(s))) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .src_n (src_n[s]),
            .sel   (sel_src[s]),
            .clr   (clr[s]),
            .pend  (pend[s])
         );

         assign active[s] = pend[s] & en[s];
      end
   endgenerate

   always_comb begin
      view_hi = '0;
      view_lo = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (src_word(s) == 1)
            view_lo[5'(src_bit(s))] = view_lo[5'(src_bit(s))] | pend[s];
         else
            view_hi[5'(src_bit(s))] = view_hi[5'(src_bit(s))] | pend[s];
      end
   end

   irqc_prio #(.NSRC(NSRC), .VEC_W(VEC_W)) u_prio (
      .req (active),
      .vec (win_vec)
   );

   assign irq_o = |active;

   always_comb begin
      case (bus_addr)
         ADDR_W'(RA_MASK_HI): bus_rdata = mask_hi;
         ADDR_W'(RA_MASK_LO): bus_rdata = mask_lo;
         ADDR_W'(RA_PEND_HI): bus_rdata = view_hi;
         ADDR_W'(RA_PEND_LO): bus_rdata = view_lo;
         ADDR_W'(RA_SENSE):   bus_rdata = sel_q;
         ADDR_W'(RA_VECTOR):  bus_rdata = {win_vec, {VEC_LSB{1'b0}}};
         default:             bus_rdata = '0;
      endcase
   end

   // R2: enable words take the written value on the next edge
   a_r2_mask_hi_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mhi |=> (mask_hi == $past(bus_wdata)));
   a_r2_mask_lo_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mlo |=> (mask_lo == $past(bus_wdata)));

   // R9: the named source is itself enabled and pending
   a_r9_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
      (win_vec != '0) |-> (pend[win_vec] && en[win_vec]));

   // R10: request output agrees with the encoder
   a_r10_irq_vs_vec: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (win_vec != '0));

   // R11: source 0 never pends
   a_r11_src0_dead: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[0]);

endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

   localparam int NSRC = 64;
   localparam int DW   = 32;
   localparam int AW   = 3;

   localparam int A_MHI = 0, A_MLO = 1, A_PHI = 2, A_PLO = 3, A_SEL = 4, A_VEC = 5;

   localparam int NT = 12;
   localparam int T_SRC [NT] = '{1, 7, 15, 16, 18, 19, 30, 32, 40, 47, 48, 63};
   localparam int T_WRD [NT] = '{0, 0, 0,  1,  1,  1,  1,  0,  0,  0,  1,  1};
   localparam int T_BIT [NT] = '{15, 9, 1, 2,  0,  14, 3,  31, 23, 16, 16, 31};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_n = '1;
   logic [AW-1:0]   bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic            irq_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_n     (src_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr  = AW'(a);
      bus_we    = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      bus_addr = AW'(a);
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [DW-1:0] vec_of(input int s);
      return DW'(s) << 26;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      for (int a = 0; a < 6; a++) begin
         rd(a, r);
         chk("R1 register reset", r, '0);
      end
      chk("R1 irq reset", DW'(irq_o), '0);

      // R2: enable word readback
      wr(A_MLO, 32'hA5A5_5A5A);
      rd(A_MLO, r);
      chk("R2 mask_lo readback", r, 32'hA5A5_5A5A);
      wr(A_MLO, 32'h0);

      // table walk: R3 placement, R2 gating, R9 vector, R10 request, R4 clear
      for (int i = 0; i < NT; i++) begin
         int s, w, b;
         s = T_SRC[i]; w = T_WRD[i]; b = T_BIT[i];
         src_n[s] = 1'b0;
         tick();
         rd(w == 1 ? A_PLO : A_PHI, r);
         chk($sformatf("R3 placement src %0d", s), r, 32'h1 << b);
         chk($sformatf("R2 masked irq src %0d", s), DW'(irq_o), '0);
         wr(w == 1 ? A_MLO : A_MHI, 32'h1 << b);
         rd(A_VEC, r);
         chk($sformatf("R9 vector src %0d", s), r, vec_of(s));
         chk($sformatf("R10 irq src %0d", s), DW'(irq_o), 32'h1);
         src_n[s] = 1'b1;
         tick();
         wr(w == 1 ? A_PLO : A_PHI, 32'h1 << b);
         wr(w == 1 ? A_MLO : A_MHI, 32'h0);
         rd(w == 1 ? A_PLO : A_PHI, r);
         chk($sformatf("R4 cleared src %0d", s), r, '0);
      end

      // R5: level source 5 (high bit 11) cannot be cleared while low
      src_n[5] = 1'b0;
      tick();
      wr(A_PHI, 32'h1 << 11);
      rd(A_PHI, r);
      chk("R5 level held through clear", r, 32'h1 << 11);
      src_n[5] = 1'b1;
      tick();
      rd(A_PHI, r);
      chk("R5 level drops on release", r, '0);

      // R6: only bits 8-14 and 16-31 of the sense register store
      wr(A_SEL, 32'hFFFF_FFFF);
      rd(A_SEL, r);
      chk("R6 sense writable bits", r, 32'hFFFF_7F00);
      wr(A_SEL, 32'h0);

      // R7 + R4: external source 19 in falling-edge mode (sense bit 14)
      wr(A_SEL, 32'h1 << 14);
      src_n[19] = 1'b0;
      tick();
      src_n[19] = 1'b1;
      tick();
      rd(A_PLO, r);
      chk("R7 edge latched after release", r, 32'h1 << 14);
      wr(A_PLO, 32'h0);
      rd(A_PLO, r);
      chk("R4 zero write leaves pending", r, 32'h1 << 14);
      wr(A_PLO, 32'h1 << 14);
      rd(A_PLO, r);
      chk("R7 edge cleared by one", r, '0);
      wr(A_SEL, 32'h0);

      // R8: port source 50 (low bit 18, sense bit 18)
      wr(A_SEL, 32'h1 << 18);
      src_n[50] = 1'b0;
      tick();
      rd(A_PLO, r);
      chk("R8 falling latched", r, 32'h1 << 18);
      wr(A_PLO, 32'h1 << 18);
      src_n[50] = 1'b1;
      tick();
      rd(A_PLO, r);
      chk("R8 rising ignored in falling mode", r, '0);
      wr(A_SEL, 32'h0);
      src_n[50] = 1'b0;
      tick();
      wr(A_PLO, 32'h1 << 18);
      src_n[50] = 1'b1;
      tick();
      rd(A_PLO, r);
      chk("R8 rising latched in both mode", r, 32'h1 << 18);
      wr(A_PLO, 32'h1 << 18);

      // R9: lowest enabled source wins among several
      wr(A_MHI, 32'hFFFF_FFFF);
      wr(A_MLO, 32'hFFFF_FFFF);
      src_n[40] = 1'b0;
      src_n[9]  = 1'b0;
      tick();
      rd(A_VEC, r);
      chk("R9 lowest of 9 and 40", r, vec_of(9));
      src_n[9] = 1'b1;
      tick();
      rd(A_VEC, r);
      chk("R9 next after release", r, vec_of(40));
      src_n[40] = 1'b1;
      tick();
      rd(A_VEC, r);
      chk("R9 none left", r, '0);
      chk("R10 irq low when none", DW'(irq_o), '0);

      // R11: source 0 is dead; sources 18 and 31 share low bit 0
      src_n[0] = 1'b0;
      tick();
      rd(A_PHI, r);
      chk("R11 source 0 never pends", r, '0);
      chk("R11 source 0 no irq", DW'(irq_o), '0);
      src_n[0] = 1'b1;
      src_n[31] = 1'b0;
      tick();
      rd(A_PLO, r);
      chk("R11 source 31 on low bit 0", r, 32'h1);
      rd(A_VEC, r);
      chk("R11 vector 31", r, vec_of(31));
      src_n[18] = 1'b0;
      tick();
      rd(A_VEC, r);
      chk("R11 shared bit, 18 wins", r, vec_of(18));
      wr(A_MLO, 32'hFFFF_FFFE);
      chk("R11 shared enable gates both", DW'(irq_o), '0);
      src_n[18] = 1'b1;
      src_n[31] = 1'b1;
      tick();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule